// File: doc/BRIEF.md
# Multichannel DAC Serial Register Interface

This block is the digital front end of a multichannel voltage DAC. A host writes 24-bit words over a four-wire serial link, most significant bit first, while chip select is held low. Each word carries a 2-bit command, a 6-bit address and a 16-bit payload. Depending on the command, the word updates a channel's output code, a channel's offset trim, a channel's gain trim, or a special-function register. The special-function registers are the control register, which holds the global power-down flag, and a small set of offset registers that each serve one group of channels.

A host reads a register back in two words. The first word selects a register through a type and an address packed into its payload. Chip select is then released, and the host clocks a second word of any content. During that second word the block returns the selected 16-bit value in the low 16 bits. The full register contents are brought out as flat buses for the analog side. Each channel also has a bus that carries the group offset it uses, which shows how later channels share the last group register.

The serial inputs are resynchronised into the system clock domain. The block samples on the rising serial-clock edge, shifts its reply on the falling edge, and commits a word when chip select rises.

Top module: `mcdac_spi_regs`

## Requirements
- R1: A word takes effect on the rising edge of chip select, and only when exactly 24 rising serial-clock edges were seen while chip select was low. The command is in bits 23:22, the address in bits 21:16 and the payload in bits 15:0. Shorter or longer words change no register.
- R2: Command 3 writes the payload to the output code of channel n, which is addressed as n+8.
- R3: Command 2 writes the payload to channel n's offset trim, and command 1 writes it to channel n's gain trim. Both use the same channel address as R2.
- R4: With command 0, a write to address 1 loads payload bit 0 into the power-down flag, which drives `power_down`. A write to address 0 is a no-operation that changes nothing.
- R5: With command 0, a write to address 2+i (i from 0 to 2) stores payload bits 13:0 into group offset register i. A write to an index at or above NUM_REF is ignored.
- R6: Channel c uses group offset register min(c / CH_PER_GRP, NUM_REF-1). That register's value appears on the channel's slice of `chan_ref_offset`.
- R7: A command-0 write to address 5 selects a readback, with the type in bits 15:13 and the address in bits 12:7. During the next word the block shifts out 24 bits, MSB first and changing after falling serial-clock edges: eight zero bits followed by the selected value.
- R8: Readback types are decoded as follows. Types 0 and 1 return the channel output code. Type 2 returns the channel offset trim. Type 3 returns the channel gain trim. Type 4 returns a special-function register: address 1 gives {15'b0, power-down}, and address 2+i gives group offset i zero-extended. Any other type or address returns 0x0000.
- R9: A selected readback value is returned only in the word that immediately follows the select word. In every other word, including one that follows a discarded word, the reply is all zeros.
- R10: Channel commands (1 to 3) aimed at an address outside 8 to 8+NUM_CH-1 are ignored.
- R11: After reset, all output codes are 0x0000, all gain trims are all-ones in the implemented bits, all offset trims are 0x8000, all group offsets are 0 and power-down is clear.
- R12: With DATA_BITS below 16, the lowest 16-DATA_BITS bits of the output code, offset trim and gain trim are stored as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial readback data to host |
| power_down | output | 1 | Global power-down flag |
| chan_data | output | NUM_CH*16 | Output codes, channel c at bits 16c+15:16c |
| chan_offset | output | NUM_CH*16 | Per-channel offset trims |
| chan_gain | output | NUM_CH*16 | Per-channel gain trims |
| ref_offset | output | NUM_REF*14 | Group offset registers |
| chan_ref_offset | output | NUM_CH*14 | Group offset in use by each channel |

## Verification
The assertions assume that the serial inputs change slowly relative to the system clock, so that every serial-clock level lasts several system cycles and a committed word is a single-cycle event. The stimulus holds each serial-clock phase for six system clocks and keeps chip select idle for several cycles between words. Under those conditions the registers and the power-down flag can change only in the cycle after a commit. The checker also relies on the host keeping the serial clock low whenever chip select changes. The bench always parks the clock low before it moves chip select, so no stray edge is counted.

// File: rtl/mcdac_pkg.sv
package mcdac_pkg;
   localparam int FRAME_W  = 24;
   localparam int WORD_W   = 16;
   localparam int ADDR_W   = 6;
   localparam int CH_BASE  = 8;
   localparam int GOFS_W   = 14;
   localparam int MAX_REF  = 3;

   typedef enum logic [1:0] {
      CMD_SPECIAL = 2'd0,
      CMD_GAIN    = 2'd1,
      CMD_OFFSET  = 2'd2,
      CMD_DATA    = 2'd3
   } cmd_e;

   localparam logic [ADDR_W-1:0] SF_NOP   = 6'd0;
   localparam logic [ADDR_W-1:0] SF_CTRL  = 6'd1;
   localparam logic [ADDR_W-1:0] SF_GOFS0 = 6'd2;
   localparam logic [ADDR_W-1:0] SF_RBSEL = 6'd5;

   localparam logic [2:0] RB_CODE_A = 3'd0;
   localparam logic [2:0] RB_CODE_B = 3'd1;
   localparam logic [2:0] RB_OFS    = 3'd2;
   localparam logic [2:0] RB_GAIN   = 3'd3;
   localparam logic [2:0] RB_SF     = 3'd4;

   typedef struct packed {
      cmd_e              cmd;
      logic [ADDR_W-1:0] addr;
      logic [WORD_W-1:0] word;
   } frame_t;
endpackage

// File: rtl/mcdac_spi_rx.sv
module mcdac_spi_rx
   import mcdac_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk,
   input  logic               cs_n,
   input  logic               mosi,
   input  logic [WORD_W-1:0]  tx_word,
   output logic               frm_end,
   output logic               frm_valid,
   output frame_t             frm,
   output logic               miso
);
   localparam int CNT_W   = 5;
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sclk_s, cs_s, mosi_s;
   logic sclk_d, cs_d;
   logic sclk_r, cs_r, mosi_r;
   logic [FRAME_W-1:0] rx_sh, tx_sh;
   logic [CNT_W-1:0]   bit_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_s <= '0;
         cs_s   <= '1;
         mosi_s <= '0;
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
      end else begin
         sclk_s <= {sclk_s[SYNC_STAGES-2:0], sclk};
         cs_s   <= {cs_s[SYNC_STAGES-2:0], cs_n};
         mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi};
         sclk_d <= sclk_s[SYNC_STAGES-1];
         cs_d   <= cs_s[SYNC_STAGES-1];
      end
   end

   assign sclk_r = sclk_s[SYNC_STAGES-1];
   assign cs_r   = cs_s[SYNC_STAGES-1];
   assign mosi_r = mosi_s[SYNC_STAGES-1];

   logic sclk_rise, sclk_fall, cs_fall, cs_rise;
   assign sclk_rise = sclk_r & ~sclk_d;
   assign sclk_fall = ~sclk_r & sclk_d;
   assign cs_fall   = ~cs_r & cs_d;
   assign cs_rise   = cs_r & ~cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh   <= '0;
         bit_cnt <= '0;
      end else if (cs_fall) begin
         bit_cnt <= '0;
      end else if (!cs_r && sclk_rise) begin
         rx_sh <= {rx_sh[FRAME_W-2:0], mosi_r};
         if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_end   <= 1'b0;
         frm_valid <= 1'b0;
      end else begin
         frm_end   <= cs_rise;
         frm_valid <= cs_rise && (bit_cnt == CNT_W'(FRAME_W));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_sh <= '0;
      else if (cs_fall) tx_sh <= {{(FRAME_W-WORD_W){1'b0}}, tx_word};
      else if (!cs_r && sclk_fall) tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
   end

   assign frm  = rx_sh;
   assign miso = tx_sh[FRAME_W-1] & ~cs_r;
endmodule

// File: rtl/mcdac_regfile.sv
module mcdac_regfile
   import mcdac_pkg::*;
#(
   parameter int NUM_CH     = 24,
   parameter int CH_PER_GRP = 8,
   parameter int NUM_REF    = 2,
   parameter int DATA_BITS  = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  frame_t                             frm,
   output logic [NUM_CH-1:0][WORD_W-1:0]      data_q,
   output logic [NUM_CH-1:0][WORD_W-1:0]      ofs_q,
   output logic [NUM_CH-1:0][WORD_W-1:0]      gain_q,
   output logic [NUM_REF-1:0][GOFS_W-1:0]     gofs_q,
   output logic [NUM_CH-1:0][GOFS_W-1:0]      ch_gofs,
   output logic                               pd_q
);
   localparam int          PAD_BITS = WORD_W - DATA_BITS;
   localparam logic [WORD_W-1:0] KEEP = ~((WORD_W'(1) << PAD_BITS) - WORD_W'(1));
   localparam logic [WORD_W-1:0] GAIN_RST = 16'hFFFF & KEEP;
   localparam logic [WORD_W-1:0] OFS_RST  = 16'h8000;

   logic sf_wr;
   assign sf_wr = wr_en && (frm.cmd == CMD_SPECIAL);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam int GRP = ch / CH_PER_GRP;
      localparam int REF = (GRP >= NUM_REF) ? NUM_REF - 1 : GRP;
      logic hit;
      logic [WORD_W-1:0] d_r, o_r, g_r;
      assign hit = wr_en && (frm.addr == ADDR_W'(CH_BASE + ch));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_r <= '0;
            o_r <= OFS_RST;
            g_r <= GAIN_RST;
         end else if (hit) begin
            case (frm.cmd)
               CMD_DATA:   d_r <= frm.word & KEEP;
               CMD_OFFSET: o_r <= frm.word & KEEP;
               CMD_GAIN:   g_r <= frm.word & KEEP;
               default:    ;
            endcase
         end
      end

      assign data_q[ch]  = d_r;
      assign ofs_q[ch]   = o_r;
      assign gain_q[ch]  = g_r;
      assign ch_gofs[ch] = gofs_q[REF];
   end

   for (genvar r = 0; r < NUM_REF; r++) begin : g_ref
      logic [GOFS_W-1:0] v_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) v_r <= '0;
         else if (sf_wr && frm.addr == (SF_GOFS0 + ADDR_W'(r)))
            v_r <= frm.word[GOFS_W-1:0];
      end
      assign gofs_q[r] = v_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pd_q <= 1'b0;
      else if (sf_wr && frm.addr == SF_CTRL) pd_q <= frm.word[0];
   end
endmodule

// File: rtl/mcdac_rb_mux.sv
module mcdac_rb_mux
   import mcdac_pkg::*;
#(
   parameter int NUM_CH  = 24,
   parameter int NUM_REF = 2
) (
   input  logic [2:0]                         sel_type,
   input  logic [ADDR_W-1:0]                  sel_addr,
   input  logic [NUM_CH-1:0][WORD_W-1:0]      data_q,
   input  logic [NUM_CH-1:0][WORD_W-1:0]      ofs_q,
   input  logic [NUM_CH-1:0][WORD_W-1:0]      gain_q,
   input  logic [NUM_REF-1:0][GOFS_W-1:0]     gofs_q,
   input  logic                               pd_q,
   output logic [WORD_W-1:0]                  value
);
   always_comb begin
      value = '0;
      case (sel_type)
         RB_CODE_A, RB_CODE_B: begin
            for (int ch = 0; ch < NUM_CH; ch++)
               if (sel_addr == ADDR_W'(CH_BASE + ch)) value = data_q[ch];
         end
         RB_OFS: begin
            for (int ch = 0; ch < NUM_CH; ch++)
               if (sel_addr == ADDR_W'(CH_BASE + ch)) value = ofs_q[ch];
         end
         RB_GAIN: begin
            for (int ch = 0; ch < NUM_CH; ch++)
               if (sel_addr == ADDR_W'(CH_BASE + ch)) value = gain_q[ch];
         end
         RB_SF: begin
            if (sel_addr == SF_CTRL) value = {{(WORD_W-1){1'b0}}, pd_q};
            for (int r = 0; r < NUM_REF; r++)
               if (sel_addr == SF_GOFS0 + ADDR_W'(r))
                  value = {{(WORD_W-GOFS_W){1'b0}}, gofs_q[r]};
         end
         default: value = '0;
      endcase
   end
endmodule

// File: rtl/mcdac_spi_regs.sv
module mcdac_spi_regs
   import mcdac_pkg::*;
#(
   parameter int NUM_CH      = 24,
   parameter int CH_PER_GRP  = 8,
   parameter int NUM_REF     = 2,
   parameter int DATA_BITS   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       spi_sclk,
   input  logic                       spi_cs_n,
   input  logic                       spi_mosi,
   output logic                       spi_miso,
   output logic                       power_down,
   output logic [NUM_CH*16-1:0]       chan_data,
   output logic [NUM_CH*16-1:0]       chan_offset,
   output logic [NUM_CH*16-1:0]       chan_gain,
   output logic [NUM_REF*14-1:0]      ref_offset,
   output logic [NUM_CH*14-1:0]       chan_ref_offset
);
   if (NUM_CH < 1 || CH_BASE + NUM_CH > (1 << ADDR_W)) begin : g_bad_ch
      $error("NUM_CH does not fit the channel address space");
   end
   if (NUM_REF < 1 || NUM_REF > MAX_REF) begin : g_bad_ref
      $error("NUM_REF must be 1 to 3");
   end
   if (CH_PER_GRP < 1) begin : g_bad_grp
      $error("CH_PER_GRP must be positive");
   end
   if (DATA_BITS < GOFS_W || DATA_BITS > WORD_W) begin : g_bad_bits
      $error("DATA_BITS must be 14 to 16");
   end

   logic   frm_end, frm_valid;
   frame_t frm;
   logic [WORD_W-1:0] rb_val, rb_hold;

   logic [NUM_CH-1:0][WORD_W-1:0]  data_q, ofs_q, gain_q;
   logic [NUM_REF-1:0][GOFS_W-1:0] gofs_q;
   logic [NUM_CH-1:0][GOFS_W-1:0]  ch_gofs;
   logic                           pd_q;

   mcdac_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n),
      .mosi(spi_mosi), .tx_word(rb_hold), .frm_end(frm_end),
      .frm_valid(frm_valid), .frm(frm), .miso(spi_miso)
   );

   mcdac_regfile #(
      .NUM_CH(NUM_CH), .CH_PER_GRP(CH_PER_GRP),
      .NUM_REF(NUM_REF), .DATA_BITS(DATA_BITS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(frm_valid), .frm(frm),
      .data_q(data_q), .ofs_q(ofs_q), .gain_q(gain_q),
      .gofs_q(gofs_q), .ch_gofs(ch_gofs), .pd_q(pd_q)
   );

   mcdac_rb_mux #(.NUM_CH(NUM_CH), .NUM_REF(NUM_REF)) u_rb (
      .sel_type(frm.word[15:13]), .sel_addr(frm.word[12:7]),
      .data_q(data_q), .ofs_q(ofs_q), .gain_q(gain_q),
      .gofs_q(gofs_q), .pd_q(pd_q), .value(rb_val)
   );

   logic rb_sel;
   assign rb_sel = frm_valid && frm.cmd == CMD_SPECIAL && frm.addr == SF_RBSEL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rb_hold <= '0;
      else if (frm_end) rb_hold <= rb_sel ? rb_val : '0;
   end

   assign power_down      = pd_q;
   assign chan_data       = data_q;
   assign chan_offset     = ofs_q;
   assign chan_gain       = gain_q;
   assign ref_offset      = gofs_q;
   assign chan_ref_offset = ch_gofs;
endmodule

// File: rtl/mcdac_sva.sv
module mcdac_sva #(
   parameter int NUM_CH    = 24,
   parameter int NUM_REF   = 2,
   parameter int DATA_BITS = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  frm_end,
   input logic                  frm_valid,
   input logic                  power_down,
   input logic [NUM_CH*16-1:0]  chan_data,
   input logic [NUM_CH*16-1:0]  chan_offset,
   input logic [NUM_CH*16-1:0]  chan_gain,
   input logic [NUM_REF*14-1:0] ref_offset
);
   // R1: a commit is only ever part of a chip-select release
   a_r1_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |-> frm_end);

   // R9: each chip-select release is a single-cycle event
   a_r9_end_single: assert property (@(posedge clk) disable iff (!rst_n)
      frm_end |=> !frm_end);

   a_r2_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> $stable(chan_data));

   a_r3_trim_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> ($stable(chan_offset) && $stable(chan_gain)));

   a_r4_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> $stable(power_down));

   a_r5_ref_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> $stable(ref_offset));

   if (DATA_BITS < 16) begin : g_pad
      localparam int PAD = 16 - DATA_BITS;
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         a_r12_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_data[ch*16 +: PAD] == '0) && (chan_offset[ch*16 +: PAD] == '0)
            && (chan_gain[ch*16 +: PAD] == '0));
      end
   end
endmodule

bind mcdac_spi_regs mcdac_sva #(
   .NUM_CH(NUM_CH), .NUM_REF(NUM_REF), .DATA_BITS(DATA_BITS)
) i_sva (
   .clk(clk), .rst_n(rst_n), .frm_end(frm_end), .frm_valid(frm_valid),
   .power_down(power_down), .chan_data(chan_data), .chan_offset(chan_offset),
   .chan_gain(chan_gain), .ref_offset(ref_offset)
);

// File: tb/test_mcdac_spi_regs.sv
module test_mcdac_spi_regs;
   localparam int NCH = 24;
   localparam int NREF = 2;
   localparam int HALF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic miso, miso_n, pd, pd_n;
   logic [NCH*16-1:0] cdata, cofs, cgain, cdata_n, cofs_n, cgain_n;
   logic [NREF*14-1:0] rofs, rofs_n;
   logic [NCH*14-1:0] crofs, crofs_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mcdac_spi_regs i_mcdac_spi_regs (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .power_down(pd), .chan_data(cdata), .chan_offset(cofs),
      .chan_gain(cgain), .ref_offset(rofs), .chan_ref_offset(crofs)
   );

   mcdac_spi_regs #(.DATA_BITS(14)) i_mcdac_spi_regs_narrow (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso_n), .power_down(pd_n), .chan_data(cdata_n), .chan_offset(cofs_n),
      .chan_gain(cgain_n), .ref_offset(rofs_n), .chan_ref_offset(crofs_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] fr(input logic [1:0] c, input logic [5:0] a,
                                      input logic [15:0] w);
      return {c, a, w};
   endfunction

   function automatic logic [23:0] rbsel(input logic [2:0] t, input logic [5:0] a);
      return {2'd0, 6'd5, t, a, 7'd0};
   endfunction

   task automatic xfer(input logic [23:0] tx, input int nbits, output logic [23:0] rx);
      rx = '0;
      @(negedge clk) cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sclk = 1'b0;
         mosi = (i < 24) ? tx[23-i] : 1'b0;
         repeat (HALF) @(negedge clk);
         rx = {rx[22:0], miso};
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   // {requirement number, write word, readback type, readback address, expected}
   localparam int NV = 12;
   localparam logic [52:0] VEC [NV] = '{
      {4'd2,  24'hC81234, 3'd0, 6'h08, 16'h1234},   // R2 channel 0 code
      {4'd2,  24'hDFBEEF, 3'd1, 6'h1F, 16'hBEEF},   // R2 channel 23, type B
      {4'd3,  24'h8D4321, 3'd2, 6'h0D, 16'h4321},   // R3 offset trim ch5
      {4'd3,  24'h510F0F, 3'd3, 6'h11, 16'h0F0F},   // R3 gain trim ch9
      {4'd5,  24'h02FFFF, 3'd4, 6'h02, 16'h3FFF},   // R5 14-bit group offset 0
      {4'd5,  24'h031555, 3'd4, 6'h03, 16'h1555},   // R5 group offset 1
      {4'd5,  24'h040AAA, 3'd4, 6'h04, 16'h0000},   // R5 index past NUM_REF ignored
      {4'd4,  24'h01FFFF, 3'd4, 6'h01, 16'h0001},   // R4 power-down set
      {4'd4,  24'h005555, 3'd4, 6'h01, 16'h0001},   // R4 no-operation
      {4'd10, 24'hF09999, 3'd0, 6'h30, 16'h0000},   // R10 undefined channel
      {4'd8,  24'h000000, 3'd5, 6'h08, 16'h0000},   // R8 undefined type
      {4'd10, 24'hC77777, 3'd0, 6'h08, 16'h1234}    // R10 address below base
   };

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [23:0] rx;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R11 reset state
      check("R11 power_down", {31'b0, pd}, 32'h0);
      check("R11 code ch0", {16'h0, cdata[15:0]}, 32'h0);
      check("R11 gain ch23", {16'h0, cgain[23*16 +: 16]}, 32'hFFFF);
      check("R11 offset ch7", {16'h0, cofs[7*16 +: 16]}, 32'h8000);
      check("R11 group offset", {4'h0, rofs}, 32'h0);
      check("R11 narrow gain", {16'h0, cgain_n[0 +: 16]}, 32'hFFFC);

      for (int v = 0; v < NV; v++) begin
         xfer(VEC[v][48:25], 24, rx);
         xfer(rbsel(VEC[v][24:22], VEC[v][21:16]), 24, rx);
         xfer(24'h0, 24, rx);
         // R7 upper byte zero, value in low 16 bits
         check($sformatf("R%0d vector %0d", VEC[v][52:49], v), {8'h0, rx},
               {16'h0, VEC[v][15:0]});
      end

      check("R4 power_down port", {31'b0, pd}, 32'h1);
      xfer(fr(2'd0, 6'd1, 16'h0000), 24, rx);
      check("R4 power_down cleared", {31'b0, pd}, 32'h0);

      // R9 reply only in the immediately following word
      xfer(rbsel(3'd0, 6'h08), 24, rx);
      xfer(24'h0, 24, rx);
      check("R9 first reply", {8'h0, rx}, 32'h1234);
      xfer(24'h0, 24, rx);
      check("R9 second reply zero", {8'h0, rx}, 32'h0);
      xfer(rbsel(3'd0, 6'h08), 24, rx);
      xfer(24'h0, 20, rx);
      xfer(24'h0, 24, rx);
      check("R9 reply after short word", {8'h0, rx}, 32'h0);

      // R1 length rules
      xfer(fr(2'd3, 6'h09, 16'hAAAA), 23, rx);
      check("R1 23-bit word dropped", {16'h0, cdata[16 +: 16]}, 32'h0);
      xfer(fr(2'd3, 6'h09, 16'hAAAA), 25, rx);
      check("R1 25-bit word dropped", {16'h0, cdata[16 +: 16]}, 32'h0);
      xfer(fr(2'd3, 6'h09, 16'hAAAA), 24, rx);
      check("R1 24-bit word taken", {16'h0, cdata[16 +: 16]}, 32'hAAAA);

      // R6 group sharing
      xfer(fr(2'd0, 6'd2, 16'h0111), 24, rx);
      xfer(fr(2'd0, 6'd3, 16'h0222), 24, rx);
      check("R6 ch0 group", {18'h0, crofs[0 +: 14]}, 32'h0111);
      check("R6 ch7 group", {18'h0, crofs[7*14 +: 14]}, 32'h0111);
      check("R6 ch8 group", {18'h0, crofs[8*14 +: 14]}, 32'h0222);
      check("R6 ch16 shares last", {18'h0, crofs[16*14 +: 14]}, 32'h0222);
      check("R6 ch23 shares last", {18'h0, crofs[23*14 +: 14]}, 32'h0222);

      // R12 narrow variant drops low bits
      check("R12 narrow code ch23", {16'h0, cdata_n[23*16 +: 16]}, 32'hBEEC);
      check("R12 narrow offset ch5", {16'h0, cofs_n[5*16 +: 16]}, 32'h4320);
      check("R12 narrow gain ch9", {16'h0, cgain_n[9*16 +: 16]}, 32'h0F0C);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule